// File: doc/BRIEF.md
# Dual-Clock Gray-Pointer FIFO

This block moves data words from a producer on one clock to a consumer on a second clock that has no fixed relationship to the first. Storage is a small register array. Each side keeps its own binary pointer, which is one bit wider than the array address so that it carries a wrap indication. Each side also publishes a registered Gray-coded copy of that pointer.

The Gray copy goes through a two-flop synchronizer into the opposite domain. Since consecutive Gray values differ in one bit, a sample taken mid-change gives either the old pointer or the new one. The read side raises its empty flag by comparing Gray values directly. The write side raises its full flag the same way, against the read pointer with its two top bits inverted. No Gray-to-binary decoding is needed anywhere.

The read port falls through. While the empty flag is low, the read data output shows the oldest unread word, and a read strobe retires that word on the next read clock edge.

Top module: `gray_xclk_fifo`

## Requirements
- R1: After both active-low resets, `empty` is 1 and `full` is 0.
- R2: Words leave in the order they were accepted. While `empty` is 0, `rdata` holds the oldest unread word, and `rd_en` high at a read clock edge retires that word.
- R3: A write strobe while `full` is 1 is ignored. The word is not stored, it does not overwrite any held word, and the write pointer does not move.
- R4: A read strobe while `empty` is 1 is ignored. The read pointer does not move, so the next word written is the next word read.
- R5: Starting empty with no reads, exactly DEPTH writes are accepted. `full` stays 0 after each of the first DEPTH-1 writes.
- R6: After a write into an empty FIFO, `empty` falls only after the pointer has passed two read-clock synchronizer flops and the flag register. Sampled at read clock falling edges after the write, it falls between the second and the fourth such edge.
- R7: `full` rises on the write clock edge that fills the last free slot. `empty` rises on the read clock edge that retires the last word. Neither flag rises without an accepted access on its own side.
- R8: Each published Gray pointer is a flop output and changes in at most one bit per edge of its own clock, including across the wrap.
- R9: Once reads have freed space and the read pointer has crossed into the write domain, `full` returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write side clock |
| wrst_n | input | 1 | Asynchronous active-low reset, write side |
| wr_en | input | 1 | Write strobe, sampled on rising `wclk` |
| wdata | input | DATA_W | Word to store |
| full | output | 1 | No free slot; writes are ignored |
| rclk | input | 1 | Read side clock |
| rrst_n | input | 1 | Asynchronous active-low reset, read side |
| rd_en | input | 1 | Read strobe, sampled on rising `rclk` |
| rdata | output | DATA_W | Oldest unread word (valid while `empty` is 0) |
| empty | output | 1 | No unread word; reads are ignored |

## Verification
The bound checker watches on every cycle that a strobe against a raised flag leaves the pointer unchanged. It also checks that each published Gray pointer steps by at most one bit, and that neither flag rises without an accepted access on its own side. Other behaviours only the bench scenarios can show. These are the data order across many wraps, the exact capacity, the window in which `empty` falls after a crossing, and `full` clearing after a drain. The bench runs the two clocks at unrelated periods and compares every read against a reference queue.

// File: rtl/gxf_pkg.sv
package gxf_pkg;

  // Reflected-binary form of a pointer value (zero-extended to 32 bits).
  function automatic logic [31:0] to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // Gray value the write pointer takes when it is exactly one lap ahead of
  // the given read pointer: top two bits of a pw-bit value flipped.
  function automatic logic [31:0] lap_ahead(input logic [31:0] g, input int pw);
    return g ^ (32'd3 << (pw - 2));
  endfunction

endpackage

// File: rtl/gxf_sync2.sv
module gxf_sync2 #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gxf_wptr.sv
module gxf_wptr #(
  parameter int AW = 4
) (
  input  logic        wclk,
  input  logic        wrst_n,
  input  logic        wr_en,
  input  logic [AW:0] rgray_s,
  output logic [AW:0] wbin,
  output logic [AW:0] wgray,
  output logic        full,
  output logic        wr_fire
);
  localparam int PW = AW + 1;

  logic [AW:0] bin_nxt, gray_nxt;
  logic        full_nxt;

  assign wr_fire  = wr_en & ~full;
  assign bin_nxt  = wbin + {{AW{1'b0}}, wr_fire};
  assign gray_nxt = PW'(gxf_pkg::to_gray(32'(bin_nxt)));
  assign full_nxt = (32'(gray_nxt) == gxf_pkg::lap_ahead(32'(rgray_s), PW));

  always_ff @(posedge wclk or negedge wrst_n)
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
      full  <= 1'b0;
    end else begin
      wbin  <= bin_nxt;
      wgray <= gray_nxt;
      full  <= full_nxt;
    end
endmodule

// File: rtl/gxf_rptr.sv
module gxf_rptr #(
  parameter int AW = 4
) (
  input  logic        rclk,
  input  logic        rrst_n,
  input  logic        rd_en,
  input  logic [AW:0] wgray_s,
  output logic [AW:0] rbin,
  output logic [AW:0] rgray,
  output logic        empty,
  output logic        rd_fire
);
  localparam int PW = AW + 1;

  logic [AW:0] bin_nxt, gray_nxt;

  assign rd_fire  = rd_en & ~empty;
  assign bin_nxt  = rbin + {{AW{1'b0}}, rd_fire};
  assign gray_nxt = PW'(gxf_pkg::to_gray(32'(bin_nxt)));

  always_ff @(posedge rclk or negedge rrst_n)
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
      empty <= 1'b1;
    end else begin
      rbin  <= bin_nxt;
      rgray <= gray_nxt;
      empty <= (gray_nxt == wgray_s);
    end
endmodule

// File: rtl/gray_xclk_fifo.sv
module gray_xclk_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic              full,
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  output logic              empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0]     wbin_q, rbin_q, wgray_q, rgray_q;
  logic [PW-1:0]     wgray_s, rgray_s;
  logic              wr_fire, rd_fire;
  logic [DATA_W-1:0] mem [DEPTH];

  gxf_wptr #(.AW(AW)) u_wside (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .rgray_s(rgray_s),
    .wbin(wbin_q), .wgray(wgray_q), .full(full), .wr_fire(wr_fire)
  );

  gxf_rptr #(.AW(AW)) u_rside (
    .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .wgray_s(wgray_s),
    .rbin(rbin_q), .rgray(rgray_q), .empty(empty), .rd_fire(rd_fire)
  );

  // write pointer into the read domain
  gxf_sync2 #(.W(PW), .STAGES(2)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .d(wgray_q), .q(wgray_s)
  );

  // read pointer into the write domain
  gxf_sync2 #(.W(PW), .STAGES(2)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .d(rgray_q), .q(rgray_s)
  );

  always_ff @(posedge wclk)
    if (wr_fire) mem[wbin_q[AW-1:0]] <= wdata;

  assign rdata = mem[rbin_q[AW-1:0]];
endmodule

// File: rtl/gray_xclk_fifo_chk.sv
module gray_xclk_fifo_chk #(
  parameter int PW = 5
) (
  input logic          wclk,
  input logic          wrst_n,
  input logic          rclk,
  input logic          rrst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          full,
  input logic          empty,
  input logic          wr_fire,
  input logic          rd_fire,
  input logic [PW-1:0] wbin,
  input logic [PW-1:0] rbin,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rgray
);
  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!wrst_n)
    (full && wr_en) |=> $stable(wbin)); // R3

  AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rrst_n)
    (empty && rd_en) |=> $stable(rbin)); // R4

  AST_WGRAY_ONE_BIT: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wgray ^ $past(wgray)) <= 1); // R8

  AST_RGRAY_ONE_BIT: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(rgray ^ $past(rgray)) <= 1); // R8

  AST_FULL_NEEDS_WRITE: assert property (@(posedge wclk) disable iff (!wrst_n)
    $rose(full) |-> $past(wr_fire)); // R7

  AST_EMPTY_NEEDS_READ: assert property (@(posedge rclk) disable iff (!rrst_n)
    $rose(empty) |-> $past(rd_fire)); // R7
endmodule

bind gray_xclk_fifo gray_xclk_fifo_chk #(.PW(AW + 1)) u_chk (
  .wclk(wclk), .wrst_n(wrst_n), .rclk(rclk), .rrst_n(rrst_n),
  .wr_en(wr_en), .rd_en(rd_en), .full(full), .empty(empty),
  .wr_fire(wr_fire), .rd_fire(rd_fire),
  .wbin(wbin_q), .rbin(rbin_q), .wgray(wgray_q), .rgray(rgray_q)
);

// File: tb/gray_xclk_fifo_bench.sv
`timescale 1ns/1ps
module gray_xclk_fifo_bench;
  localparam int DW    = 8;
  localparam int DEPTH = 16;

  typedef struct packed {
    logic          exp_full;
    logic [DW-1:0] data;
  } vec_t;

  // fill pattern: FULL expected only after the last slot is taken
  localparam vec_t VEC [DEPTH] = '{
    '{1'b0, 8'h11}, '{1'b0, 8'h93}, '{1'b0, 8'h2C}, '{1'b0, 8'hF0},
    '{1'b0, 8'h07}, '{1'b0, 8'hB8}, '{1'b0, 8'h64}, '{1'b0, 8'hCD},
    '{1'b0, 8'h3A}, '{1'b0, 8'h81}, '{1'b0, 8'h4F}, '{1'b0, 8'hD6},
    '{1'b0, 8'h19}, '{1'b0, 8'hA2}, '{1'b0, 8'h75}, '{1'b1, 8'hFE}
  };

  logic          wclk = 0, rclk = 0;
  logic          wrst_n = 0, rrst_n = 0;
  logic          wr_en = 0, rd_en = 0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          full, empty;

  int n_run = 0, n_fail = 0;
  logic [DW-1:0] refq [$];
  bit wdone = 0;

  always #2   wclk = ~wclk;   // 250 MHz
  always #3.3 rclk = ~rclk;   // unrelated read clock

  gray_xclk_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) u_gray_xclk_fifo (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wdata(wdata), .full(full),
    .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .rdata(rdata), .empty(empty)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  task automatic push_word(input logic [DW-1:0] d);
    @(negedge wclk);
    wr_en = 1; wdata = d;
    @(negedge wclk);
    wr_en = 0;
  endtask

  task automatic pop_word(output logic [DW-1:0] d);
    @(negedge rclk);
    while (empty) @(negedge rclk);
    d = rdata; rd_en = 1;
    @(negedge rclk);
    rd_en = 0;
  endtask

  initial begin
    #400us;
    chk(1'b0, "watchdog", 0, 1);
    report();
    $finish;
  end

  initial begin
    logic [DW-1:0] got;
    int n;
    repeat (3) @(negedge wclk);
    wrst_n = 1; rrst_n = 1;
    @(negedge rclk); @(negedge wclk);
    chk(empty == 1'b1, "R1 empty", int'(empty), 1);
    chk(full == 1'b0, "R1 full", int'(full), 0);

    // table walk: fill from empty with no reads
    for (int i = 0; i < DEPTH; i++) begin
      push_word(VEC[i].data);
      if (i < DEPTH - 1) chk(full == VEC[i].exp_full, "R5 full early", int'(full), int'(VEC[i].exp_full));
      else               chk(full == VEC[i].exp_full, "R7 full on last write", int'(full), int'(VEC[i].exp_full));
    end

    // writes while full must be dropped
    @(negedge wclk); wr_en = 1; wdata = 8'hEE;
    repeat (3) @(negedge wclk);
    wr_en = 0;
    chk(full == 1'b1, "R3 full held", int'(full), 1);

    repeat (6) @(negedge rclk);
    for (int i = 0; i < DEPTH; i++) begin
      pop_word(got);
      chk(got == VEC[i].data, "R2/R3 drain order", int'(got), int'(VEC[i].data));
    end
    chk(empty == 1'b1, "R7 empty on last read", int'(empty), 1);

    repeat (6) @(negedge wclk);
    chk(full == 1'b0, "R9 full cleared", int'(full), 0);

    // reads while empty must be dropped
    @(negedge rclk); rd_en = 1;
    repeat (3) @(negedge rclk);
    rd_en = 0;
    chk(empty == 1'b1, "R4 empty held", int'(empty), 1);

    push_word(8'h5A);
    n = 0;
    while (empty && n < 10) begin
      @(negedge rclk);
      n++;
    end
    chk(n >= 2 && n <= 4, "R6 empty latency", n, 3);
    pop_word(got);
    chk(got == 8'h5A, "R4 no pointer skip", int'(got), 8'h5A);
    chk(empty == 1'b1, "R7 empty after single", int'(empty), 1);

    // random traffic on both clocks; pointers wrap many times (R8)
    fork
      begin : writer
        int sent = 0;
        while (sent < 600) begin
          bit want;
          @(negedge wclk);
          want = ($urandom % 100) < ((sent < 300) ? 85 : 35);
          wr_en = want;
          wdata = DW'($urandom);
          if (want && !full) begin
            refq.push_back(wdata);
            sent++;
          end
          if (refq.size() > DEPTH)
            chk(1'b0, "R3 overflow", refq.size(), DEPTH);
        end
        @(negedge wclk); wr_en = 0;
        wdone = 1;
      end
      begin : reader
        int guard = 0;
        while (!(wdone && refq.size() == 0) && guard < 40000) begin
          @(negedge rclk);
          guard++;
          rd_en = 0;
          if (!empty) begin
            if (refq.size() == 0) chk(1'b0, "R4 underflow", 0, 1);
            else if (($urandom % 100) < 55) begin
              chk(rdata == refq[0], "R2/R8 random order", int'(rdata), int'(refq[0]));
              void'(refq.pop_front());
              rd_en = 1;
            end
          end else begin
            rd_en = ($urandom % 2) == 1;
          end
        end
        @(negedge rclk); rd_en = 0;
      end
    join

    repeat (4) @(negedge rclk);
    chk(empty == 1'b1, "R2 drained", int'(empty), 1);
    repeat (6) @(negedge wclk);
    chk(full == 1'b0, "R9 full after random", int'(full), 0);

    report();
    $finish;
  end
endmodule